// File: doc/BRIEF.md
# Endpoint Count and Status Register Bank

This block holds the count and status registers for the three endpoints of a low-speed USB function. Each endpoint has one 8-bit register. It carries a data-toggle bit, a data-valid bit, two reserved bits and a 4-bit byte count. Firmware reaches the registers through a simple address/data port. The serial interface engine reaches them through an update strobe, which it raises when an OUT or SETUP data packet completes. For IN transfers, the stored count and toggle of every endpoint go to the transmitter on dedicated outputs.

When the engine updates a register, the received toggle is recorded and the count is set to the payload length plus the two CRC bytes. The valid bit shows whether the packet arrived without error. The endpoint-0 register also protects a fresh hardware update: after one, firmware writes to it are dropped until firmware reads it. The two other endpoints never lock.

Top module: `ep_status_regs`

## Requirements
- R1: After reset, every endpoint register reads 0x00 and endpoint 0 is unlocked.
- R2: Endpoints 0, 1 and 2 answer at addresses 0x41, 0x43 and 0x45. Every other address reads 0x00, and writes to it change nothing.
- R3: Register layout: bit 7 is the toggle (0 = DATA0, 1 = DATA1), bit 6 is data valid and bits 3:0 are the count. Bits 5:4 always read 0 and ignore writes.
- R4: A CPU write that is accepted stores bit 7, bit 6 and bits 3:0 of the write data. A written count above 8 is stored as 8.
- R5: `tx_toggle[i]` and `tx_count[4*i+3:4*i]` always show the stored toggle and count of endpoint i.
- R6: A hardware update stores the received toggle and the count min(received bytes, 8) + 2. The resulting count lies between 2 and 10.
- R7: A hardware update sets data valid when none of the CRC, bit-stuff or PID error flags is high, and clears it when any of them is high.
- R8: A hardware update of endpoint 0 locks it. While it is locked, CPU writes to it are ignored.
- R9: A CPU read of address 0x41 releases the lock, unless a hardware update of endpoint 0 happens in the same cycle. In that case the register stays locked.
- R10: Endpoints 1 and 2 never lock. A CPU write to them right after a hardware update is stored.
- R11: When a hardware update and a CPU write target the same endpoint in the same cycle, the hardware update is stored. An update whose endpoint number is 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | CPU register address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (releases the endpoint-0 lock) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data of the addressed register, combinational |
| sie_upd | input | 1 | OUT/SETUP completion strobe |
| sie_ep | input | 2 | Endpoint number of the completion |
| sie_rx_bytes | input | 4 | Number of received data bytes |
| sie_rx_toggle | input | 1 | Received data toggle |
| sie_crc_err | input | 1 | CRC error seen |
| sie_stuff_err | input | 1 | Bit-stuff error seen |
| sie_pid_err | input | 1 | PID error seen |
| tx_count | output | 12 | Stored counts, 4 bits per endpoint |
| tx_toggle | output | 3 | Stored toggles, 1 bit per endpoint |

## Verification
The bench sweeps all 256 write values into each endpoint, including counts 9 to 15. A design without saturation would return those counts as written, and one that stored the reserved bits would read them back. It drives every received length from 0 to 15 with both toggles and all eight error-flag combinations. A design that dropped the +2 offset, mixed up error flags or mis-clamped the length gives the wrong count or valid bit. The lock tests cover these cases:
- a write after an endpoint-0 update, which a non-locking design would store;
- a write after the releasing read;
- a read that coincides with an update, which a careless release would wrongly unlock;
- updates and writes in the same cycle;
- updates and writes on endpoints 1 and 2, which must never lock.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;
  localparam int REG_W     = 8;
  localparam int CNT_W     = 4;
  localparam int RSVD_W    = REG_W - 2 - CNT_W;
  localparam int MAX_IN    = 8;
  localparam int CRC_BYTES = 2;

  typedef struct packed {
    logic             toggle;
    logic             valid;
    logic [CNT_W-1:0] count;
  } ep_reg_t;

  // Limit a count to the largest payload an endpoint can hold.
  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] v);
    return (v > CNT_W'(MAX_IN)) ? CNT_W'(MAX_IN) : v;
  endfunction

  // Count recorded for a received packet: payload plus CRC bytes.
  function automatic logic [CNT_W-1:0] rx_field(input logic [CNT_W-1:0] rx);
    return clamp_count(rx) + CNT_W'(CRC_BYTES);
  endfunction

  // Register image as seen by the CPU; reserved bits are zero.
  function automatic logic [REG_W-1:0] pack_reg(input ep_reg_t r);
    return {r.toggle, r.valid, {RSVD_W{1'b0}}, r.count};
  endfunction
endpackage

// File: rtl/ep_status_addr_dec.sv
module ep_status_addr_dec #(
  parameter int NUM_EP    = 3,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h41,
  parameter int STRIDE    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_EP-1:0] hit
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
    assign hit[i] = (addr == ADDR_W'(BASE_ADDR + i * STRIDE));
  end
endmodule

// File: rtl/ep_status_reg.sv
module ep_status_reg
  import ep_status_pkg::*;
#(
  parameter bit LOCKABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             upd_hit,
  input  logic [CNT_W-1:0] rx_bytes,
  input  logic             rx_toggle,
  input  logic             rx_err,
  output ep_reg_t          q,
  output logic             locked
);
  logic wr_accept;
  logic lock_set;
  logic lock_clear;
  logic unused_rsvd;

  assign unused_rsvd = ^wdata[REG_W-3:CNT_W];
  assign wr_accept   = wr_hit && !locked;
  assign lock_set    = LOCKABLE && upd_hit;
  assign lock_clear  = LOCKABLE && rd_hit && !upd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd_hit) begin
      q.toggle <= rx_toggle;
      q.valid  <= !rx_err;
      q.count  <= rx_field(rx_bytes);
    end else if (wr_accept) begin
      q.toggle <= wdata[REG_W-1];
      q.valid  <= wdata[REG_W-2];
      q.count  <= clamp_count(wdata[CNT_W-1:0]);
    end
  end

  if (LOCKABLE) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n)          locked <= 1'b0;
      else if (lock_set)   locked <= 1'b1;
      else if (lock_clear) locked <= 1'b0;
    end

    // R8
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_hit |=> locked);
    // R8
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && locked && !upd_hit) |=> $stable(q));
    // R9
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && locked && !upd_hit) |=> !locked);
  end else begin : g_nolock
    assign locked = 1'b0;
    // R10
    free_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !upd_hit) |=> (q.toggle == $past(wdata[REG_W-1])));
  end

  // R6
  hw_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_hit |=> (q.count >= CNT_W'(CRC_BYTES) && q.count <= CNT_W'(MAX_IN + CRC_BYTES)));
  // R4
  in_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !upd_hit) |=> (q.count <= CNT_W'(MAX_IN)));
  // R7
  valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_hit |=> (q.valid == !$past(rx_err)));
endmodule

// File: rtl/ep_status_regs.sv
module ep_status_regs
  import ep_status_pkg::*;
#(
  parameter int NUM_EP    = 3,
  parameter int ADDR_W    = 8,
  parameter int EP_W      = 2,
  parameter int BASE_ADDR = 'h41,
  parameter int STRIDE    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_wr,
  input  logic                    cpu_rd,
  input  logic [REG_W-1:0]        cpu_wdata,
  output logic [REG_W-1:0]        cpu_rdata,
  input  logic                    sie_upd,
  input  logic [EP_W-1:0]         sie_ep,
  input  logic [CNT_W-1:0]        sie_rx_bytes,
  input  logic                    sie_rx_toggle,
  input  logic                    sie_crc_err,
  input  logic                    sie_stuff_err,
  input  logic                    sie_pid_err,
  output logic [NUM_EP*CNT_W-1:0] tx_count,
  output logic [NUM_EP-1:0]       tx_toggle
);
  logic [NUM_EP-1:0] addr_hit;
  logic [NUM_EP-1:0] upd_hit;
  logic [NUM_EP-1:0] ep_locked;
  logic              rx_err;
  ep_reg_t           regs [NUM_EP];
  logic [REG_W-1:0]  rd_terms [NUM_EP];

  assign rx_err = sie_crc_err || sie_stuff_err || sie_pid_err;

  ep_status_addr_dec #(
    .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
  ) u_dec (
    .addr(cpu_addr),
    .hit (addr_hit)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign upd_hit[i] = sie_upd && (sie_ep == EP_W'(i));

    ep_status_reg #(.LOCKABLE(i == 0)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (cpu_wr && addr_hit[i]),
      .rd_hit   (cpu_rd && addr_hit[i]),
      .wdata    (cpu_wdata),
      .upd_hit  (upd_hit[i]),
      .rx_bytes (sie_rx_bytes),
      .rx_toggle(sie_rx_toggle),
      .rx_err   (rx_err),
      .q        (regs[i]),
      .locked   (ep_locked[i])
    );

    assign tx_count[i*CNT_W +: CNT_W] = regs[i].count;
    assign tx_toggle[i]               = regs[i].toggle;
    assign rd_terms[i] = addr_hit[i] ? pack_reg(regs[i]) : '0;
  end

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < NUM_EP; i++) cpu_rdata |= rd_terms[i];
  end

  // R2
  addr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_hit));
  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[REG_W-3:CNT_W] == '0);
  // R11
  bad_ep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_upd && sie_ep >= EP_W'(NUM_EP) && !cpu_wr) |=> ($stable(tx_count) && $stable(tx_toggle)));
  // R10
  ep12_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_locked[NUM_EP-1:1] == '0);
endmodule

// File: tb/ep_status_regs_test.sv
`timescale 1ns/1ps
module ep_status_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  cpu_addr = 0;
  logic        cpu_wr = 0, cpu_rd = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [7:0]  cpu_rdata;
  logic        sie_upd = 0;
  logic [1:0]  sie_ep = 0;
  logic [3:0]  sie_rx_bytes = 0;
  logic        sie_rx_toggle = 0, sie_crc_err = 0, sie_stuff_err = 0, sie_pid_err = 0;
  logic [11:0] tx_count;
  logic [2:0]  tx_toggle;

  int checks = 0, errors = 0;
  logic       m_tog [3];
  logic       m_val [3];
  int         m_cnt [3];
  logic       m_lock;

  always #4 clk = ~clk;

  ep_status_regs uut (.*);

  function automatic logic [7:0] img(int e);
    return {m_tog[e], m_val[e], 2'b00, 4'(m_cnt[e])};
  endfunction

  function automatic int ep_of(logic [7:0] a);
    if (a == 8'h41) return 0;
    if (a == 8'h43) return 1;
    if (a == 8'h45) return 2;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Observe all registers without releasing the lock.
  task automatic check_all(string tag);
    for (int e = 0; e < 3; e++) begin
      cpu_addr = 8'h41 + 8'(2 * e);
      #1;
      chk(tag, cpu_rdata, img(e));
      chk({tag, " tx"}, {tx_toggle[e], tx_count[4*e +: 4]}, {m_tog[e], 4'(m_cnt[e])});
    end
  endtask

  // One cycle of stimulus, applied from a falling edge; model updated after.
  task automatic cyc(bit wr, bit rd, logic [7:0] a, logic [7:0] wd,
                     bit upd, logic [1:0] ep, logic [3:0] rx, bit tg, logic [2:0] er);
    int he;
    @(negedge clk);
    cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = wd;
    sie_upd = upd; sie_ep = ep; sie_rx_bytes = rx; sie_rx_toggle = tg;
    {sie_crc_err, sie_stuff_err, sie_pid_err} = er;
    #1;
    he = ep_of(a);
    if (rd) chk("R2 read data", cpu_rdata, he < 0 ? 0 : img(he));
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; sie_upd = 0;
    for (int e = 0; e < 3; e++) begin
      if (upd && ep == 2'(e)) begin
        m_tog[e] = tg; m_val[e] = (er == 0);
        m_cnt[e] = (rx > 8 ? 8 : int'(rx)) + 2;
        if (e == 0) m_lock = 1;
      end else if (wr && he == e && !(e == 0 && m_lock)) begin
        m_tog[e] = wd[7]; m_val[e] = wd[6];
        m_cnt[e] = (wd[3:0] > 8) ? 8 : int'(wd[3:0]);
      end
    end
    if (rd && he == 0 && !(upd && ep == 0)) m_lock = 0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int e = 0; e < 3; e++) begin m_tog[e] = 0; m_val[e] = 0; m_cnt[e] = 0; end
    m_lock = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");
    // R4 R3 R5: sweep all write values into each endpoint
    for (int e = 0; e < 3; e++)
      for (int v = 0; v < 256; v++) begin
        cyc(1, 0, 8'h41 + 8'(2 * e), 8'(v), 0, 0, 0, 0, 0);
        check_all("R4 R3 write sweep");
      end
    // R2: unmapped addresses
    cyc(1, 0, 8'h41, 8'hC5, 0, 0, 0, 0, 0);
    foreach (m_tog[e]) ;
    for (int a = 8'h40; a < 8'h48; a++) begin
      if (ep_of(8'(a)) < 0) begin
        cyc(1, 1, 8'(a), 8'hFF, 0, 0, 0, 0, 0);
        check_all("R2 unmapped write");
      end
    end
    // R6 R7 R8 R9 R10: hardware update sweep
    for (int e = 0; e < 3; e++)
      for (int rx = 0; rx < 16; rx++)
        for (int tg = 0; tg < 2; tg++)
          for (int er = 0; er < 8; er++) begin
            cyc(0, 0, 8'h00, 0, 1, 2'(e), 4'(rx), tg[0], 3'(er));
            check_all("R6 R7 hw update");
            // a write right after the update: dropped on ep0, kept on ep1/2
            cyc(1, 0, 8'h41 + 8'(2 * e), 8'(rx * 16 + er), 0, 0, 0, 0, 0);
            check_all(e == 0 ? "R8 locked write" : "R10 no lock");
            cyc(0, 1, 8'h41, 0, 0, 0, 0, 0, 0);
            cyc(1, 0, 8'h41, 8'(er * 32 + rx), 0, 0, 0, 0, 0);
            check_all("R9 write after unlock");
          end
    // R11: hw wins over same-cycle write
    for (int e = 0; e < 3; e++) begin
      cyc(0, 1, 8'h41, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 8'h41 + 8'(2 * e), 8'h47, 1, 2'(e), 4'd5, 0, 3'b010);
      check_all("R11 hw wins");
    end
    // R9: read in the same cycle as an ep0 update keeps the lock
    cyc(0, 1, 8'h41, 0, 1, 0, 4'd3, 1, 0);
    cyc(1, 0, 8'h41, 8'h08, 0, 0, 0, 0, 0);
    check_all("R9 read during update");
    // R9: locked write and read in the same cycle: write dropped, lock released
    cyc(1, 1, 8'h41, 8'h02, 0, 0, 0, 0, 0);
    check_all("R9 write with read");
    cyc(1, 0, 8'h41, 8'h86, 0, 0, 0, 0, 0);
    check_all("R9 unlocked write");
    // R11: endpoint number 3 ignored
    cyc(0, 0, 8'h00, 0, 1, 2'd3, 4'd7, 1, 0);
    check_all("R11 ep3 ignored");
    cyc(1, 0, 8'h41, 8'h43, 0, 0, 0, 0, 0);
    check_all("R11 ep3 no lock");
    // R1: reset again clears all state
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    for (int e = 0; e < 3; e++) begin m_tog[e] = 0; m_val[e] = 0; m_cnt[e] = 0; end
    m_lock = 0;
    check_all("R1 re-reset");
    cyc(1, 0, 8'h41, 8'h45, 0, 0, 0, 0, 0);
    check_all("R1 unlocked after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule